// File: doc/BRIEF.md
# Single-Step Decode Rate Gate

This block sets the pace at which a video decoder starts reconstructing pictures. It watches three events from the header parser: a picture start code, the first slice start code of that picture, and the end of picture header processing. Once all three have been handled for the current picture, the block holds that picture at a gate. It then issues a one-cycle proceed strobe that lets reconstruction of the picture begin.

Two pacing rules apply at the gate. In normal pacing, the picture is released by the next display vertical sync. In fast-forward stepping, vertical sync is ignored and the picture is released by a single-step bit that the host sets. The block clears that bit itself when it uses it, so each host step releases exactly one picture. The stepping enable and the step bit are written together through one control word.

Top module: `pace_gate`

## Requirements
- R1: After reset, `proceed_o` is low, normal (vsync) pacing is selected, no step is pending and no header progress is held.
- R2: The gate is reached only when a picture start, a slice start and a header-done event have all been seen for one picture. Slice and header-done may come in either order, but both must follow the picture start. Slice or header-done events with no picture start before them are ignored.
- R3: In normal pacing, suppose header-done completes the gate in cycle h and the first vsync in a cycle v > h is sampled. Then `proceed_o` is high in cycle v+1 only. A vsync in cycle h itself does not release the picture.
- R4: A control write sets the pacing mode from bit 0 of `ctl_wdata_i` (1 = stepping) and, when bit 1 is 1, sets the step bit. While stepping is selected, vsync has no effect.
- R5: In stepping mode with the gate reached, a step written in cycle w gives `proceed_o` high in cycle w+2.
- R6: Using the step clears it, so the next picture waits at its gate until another step is written.
- R7: A step written before the gate is reached stays pending. If the gate is then completed in cycle h, `proceed_o` is high in cycle h+2.
- R8: A step write that lands in the same cycle as a step being used leaves a fresh step pending for the next picture.
- R9: A picture start arriving before the gate is reached restarts the header progress, and any slice or header-done already seen is forgotten.
- R10: Clearing the stepping enable while a picture waits at the gate returns that picture to vsync pacing. A pending step is neither used nor cleared while normal pacing is selected.
- R11: Parser events that arrive while a picture waits at the gate are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 1 | Display vertical sync pulse |
| pic_start_i | input | 1 | Picture start code seen |
| slice_start_i | input | 1 | Slice start code seen |
| hdr_done_i | input | 1 | Picture header processing finished |
| ctl_wr_i | input | 1 | Host write strobe for the control word |
| ctl_wdata_i | input | CTL_W | Control word: bit 0 stepping enable, bit 1 single step |
| proceed_o | output | 1 | One-cycle strobe releasing the waiting picture for decode |

## Verification
Two functions of the block can fall in the same cycle: the step latch using up a pending step to release a picture, and a new host step write. The bench provokes this by writing a step while a picture waits, then writing a second step on the very next cycle, which is when the first one is used. The result is judged on the following picture: it must be released two cycles after its header completes, with no further write. A second collision is also covered, where vsync arrives in the same cycle that header-done completes the gate; that vsync must not release the picture.

// File: rtl/pace_pkg.sv
package pace_pkg;

    // Progress of header parsing for the current picture
    typedef struct packed {
        logic pic;   // picture start seen
        logic slc;   // first slice start seen
        logic hdr;   // header processing finished
    } trk_t;

    // Host control state
    typedef struct packed {
        logic fast;  // stepping pacing selected
        logic step;  // single step pending
    } ctl_t;

    // Output register
    typedef struct packed {
        logic proceed;
    } out_t;

endpackage

// File: rtl/pace_track.sv
module pace_track
    import pace_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pic_start_i,
    input  logic slice_start_i,
    input  logic hdr_done_i,
    input  logic release_i,
    output logic armed_o
);

    trk_t trk_d, trk_q;
    logic armed;

    assign armed   = trk_q.pic & trk_q.slc & trk_q.hdr;
    assign armed_o = armed;

    always_comb begin
        trk_d = trk_q;
        if (armed) begin
            // Waiting at the gate: parser events are ignored
            if (release_i) begin
                trk_d = '0;
            end
        end else if (pic_start_i) begin
            // A new picture start restarts tracking
            trk_d.pic = 1'b1;
            trk_d.slc = 1'b0;
            trk_d.hdr = 1'b0;
        end else if (trk_q.pic) begin
            if (slice_start_i) begin
                trk_d.slc = 1'b1;
            end
            if (hdr_done_i) begin
                trk_d.hdr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

endmodule

// File: rtl/pace_ctl.sv
module pace_ctl
    import pace_pkg::*;
#(
    parameter int CTL_W    = 2,
    parameter int MODE_BIT = 0,
    parameter int STEP_BIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CTL_W-1:0] wdata_i,
    input  logic             consume_i,
    output logic             fast_o,
    output logic             step_o
);

    ctl_t ctl_d, ctl_q;
    logic set_step;

    assign set_step = wr_i & wdata_i[STEP_BIT];
    assign fast_o   = ctl_q.fast;
    assign step_o   = ctl_q.step;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_i) begin
            ctl_d.fast = wdata_i[MODE_BIT];
        end
        // A write in the consuming cycle re-arms the step
        ctl_d.step = (ctl_q.step & ~consume_i) | set_step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/pace_decide.sv
module pace_decide (
    input  logic armed_i,
    input  logic fast_i,
    input  logic step_i,
    input  logic vsync_i,
    output logic go_o,
    output logic consume_o
);

    always_comb begin
        go_o      = 1'b0;
        consume_o = 1'b0;
        if (armed_i) begin
            if (fast_i) begin
                go_o      = step_i;
                consume_o = step_i;
            end else begin
                go_o      = vsync_i;
            end
        end
    end

endmodule

// File: rtl/pace_gate.sv
module pace_gate
    import pace_pkg::*;
#(
    parameter int CTL_W    = 2,
    parameter int MODE_BIT = 0,
    parameter int STEP_BIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vsync_i,
    input  logic             pic_start_i,
    input  logic             slice_start_i,
    input  logic             hdr_done_i,
    input  logic             ctl_wr_i,
    input  logic [CTL_W-1:0] ctl_wdata_i,
    output logic             proceed_o
);

    logic armed;
    logic fast;
    logic step;
    logic go;
    logic consume;
    out_t out_d, out_q;

    pace_track u_track (
        .clk           (clk),
        .rst_n         (rst_n),
        .pic_start_i   (pic_start_i),
        .slice_start_i (slice_start_i),
        .hdr_done_i    (hdr_done_i),
        .release_i     (go),
        .armed_o       (armed)
    );

    pace_ctl #(
        .CTL_W    (CTL_W),
        .MODE_BIT (MODE_BIT),
        .STEP_BIT (STEP_BIT)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (ctl_wr_i),
        .wdata_i   (ctl_wdata_i),
        .consume_i (consume),
        .fast_o    (fast),
        .step_o    (step)
    );

    pace_decide u_decide (
        .armed_i   (armed),
        .fast_i    (fast),
        .step_i    (step),
        .vsync_i   (vsync_i),
        .go_o      (go),
        .consume_o (consume)
    );

    always_comb begin
        out_d         = out_q;
        out_d.proceed = go;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign proceed_o = out_q.proceed;

endmodule

// File: rtl/pace_gate_chk.sv
module pace_gate_chk #(
    parameter int CTL_W    = 2,
    parameter int STEP_BIT = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vsync_i,
    input logic             ctl_wr_i,
    input logic [CTL_W-1:0] ctl_wdata_i,
    input logic             proceed_o,
    input logic             armed,
    input logic             fast,
    input logic             step
);

    // R3: the release is a single-cycle strobe
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        proceed_o |=> !proceed_o);

    // R3: in normal pacing a release follows a sampled vsync
    p_vsync_paced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (proceed_o && !$past(fast)) |-> $past(vsync_i));

    // R2: a release only comes from a reached gate, and empties the tracking
    p_gate_reached_r2: assert property (@(posedge clk) disable iff (!rst_n)
        proceed_o |-> ($past(armed) && !armed));

    // R5: in stepping mode a release needs a pending step
    p_step_needed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (proceed_o && $past(fast)) |-> $past(step));

    // R6: the used step is cleared unless rewritten in that cycle
    p_step_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (proceed_o && $past(fast) && !$past(ctl_wr_i && ctl_wdata_i[STEP_BIT])) |-> !step);

    // R10: in normal pacing a pending step is never dropped without a write
    p_step_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(step) && !$past(fast)) |-> step);

endmodule

bind pace_gate pace_gate_chk #(
    .CTL_W    (CTL_W),
    .STEP_BIT (STEP_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vsync_i     (vsync_i),
    .ctl_wr_i    (ctl_wr_i),
    .ctl_wdata_i (ctl_wdata_i),
    .proceed_o   (proceed_o),
    .armed       (armed),
    .fast        (fast),
    .step        (step)
);

// File: tb/pace_gate_test.sv
module pace_gate_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       vsync_i;
    logic       pic_start_i;
    logic       slice_start_i;
    logic       hdr_done_i;
    logic       ctl_wr_i;
    logic [1:0] ctl_wdata_i;
    logic       proceed_o;

    always #5 clk = ~clk;

    pace_gate uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .vsync_i       (vsync_i),
        .pic_start_i   (pic_start_i),
        .slice_start_i (slice_start_i),
        .hdr_done_i    (hdr_done_i),
        .ctl_wr_i      (ctl_wr_i),
        .ctl_wdata_i   (ctl_wdata_i),
        .proceed_o     (proceed_o)
    );

    typedef struct {
        int    at;
        string req;
    } exp_t;

    exp_t  sb[$];
    exp_t  got;
    int    cyc    = 0;
    int    at     = 0;
    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done   = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop the scoreboard on every strobe
    always @(negedge clk) begin
        if (rst_n === 1'b1 && proceed_o === 1'b1) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL %s proceed at cycle %0d, expected none", cur_req, cyc);
            end else begin
                got = sb.pop_front();
                if (got.at != cyc) begin
                    errors++;
                    $display("FAIL %s proceed at cycle %0d, expected cycle %0d", got.req, cyc, got.at);
                end
            end
        end
    end

    task automatic summary();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL %s watchdog expired, got hang expected completion", cur_req);
            summary();
            $finish;
        end
    end

    task automatic drive(input logic p, input logic s, input logic h,
                         input logic v, input logic w, input logic [1:0] d);
        @(negedge clk);
        pic_start_i   = p;
        slice_start_i = s;
        hdr_done_i    = h;
        vsync_i       = v;
        ctl_wr_i      = w;
        ctl_wdata_i   = d;
        at            = cyc;
    endtask

    task automatic idle(input int n);
        repeat (n) drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00);
    endtask

    task automatic pic();  drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00); endtask
    task automatic slc();  drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00); endtask
    task automatic hdr();  drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00); endtask
    task automatic vs();   drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00); endtask
    task automatic wr(input logic [1:0] d); drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, d); endtask

    task automatic expect_at(input int when, input string r);
        exp_t e;
        e.at  = when;
        e.req = r;
        sb.push_back(e);
    endtask

    initial begin
        rst_n         = 1'b0;
        vsync_i       = 1'b0;
        pic_start_i   = 1'b0;
        slice_start_i = 1'b0;
        hdr_done_i    = 1'b0;
        ctl_wr_i      = 1'b0;
        ctl_wdata_i   = 2'b00;

        // R1: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (proceed_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 proceed_o=%b in reset, expected 0", proceed_o);
        end
        rst_n = 1'b1;
        idle(2);

        // R3 (and R1 normal pacing): vsync with header-done does not count
        cur_req = "R3";
        pic(); slc();
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00);
        idle(2);
        vs(); expect_at(at + 1, "R1/R3");
        idle(3);

        // R2: slice/header before picture start ignored; order slice-after-header works
        cur_req = "R2";
        slc(); hdr(); vs(); idle(2);
        pic(); hdr(); vs(); idle(2);
        slc(); vs(); expect_at(at + 1, "R2");
        idle(3);

        // R9: second picture start forgets the seen slice
        cur_req = "R9";
        pic(); slc(); pic(); hdr(); vs(); idle(2);
        slc(); vs(); expect_at(at + 1, "R9");
        idle(3);

        // R4/R5: stepping mode ignores vsync, step releases at w+2
        cur_req = "R4";
        wr(2'b01); idle(1);
        pic(); slc(); hdr(); vs(); idle(1); vs(); idle(3);
        cur_req = "R5";
        wr(2'b11); expect_at(at + 2, "R5");
        idle(3);

        // R6: step was used up; next picture needs a new write
        cur_req = "R6";
        pic(); slc(); hdr(); idle(4); vs(); idle(3);
        wr(2'b11); expect_at(at + 2, "R6");
        idle(3);

        // R7: step written early stays pending
        cur_req = "R7";
        wr(2'b11); idle(3);
        pic(); slc(); hdr(); expect_at(at + 2, "R7");
        idle(3);

        // R8: write in the consuming cycle re-arms the step
        cur_req = "R8";
        pic(); slc(); hdr(); idle(2);
        wr(2'b11); expect_at(at + 2, "R8");
        wr(2'b11);
        idle(2);
        pic(); slc(); hdr(); expect_at(at + 2, "R8");
        idle(3);

        // R11: picture start while waiting is ignored
        cur_req = "R11";
        pic(); slc(); hdr(); idle(2);
        pic(); idle(1);
        wr(2'b11); expect_at(at + 2, "R11");
        idle(3);

        // R10: leaving stepping while waiting reverts to vsync
        cur_req = "R10";
        pic(); slc(); hdr(); idle(2);
        wr(2'b00); idle(2);
        vs(); expect_at(at + 1, "R10");
        idle(3);
        // R10: step pending in normal pacing is kept
        wr(2'b10); idle(1);
        pic(); slc(); hdr(); idle(1);
        vs(); expect_at(at + 1, "R10");
        idle(3);
        wr(2'b01); idle(1);
        pic(); slc(); hdr(); expect_at(at + 2, "R10");
        idle(5);

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL %s %0d expected strobes missing, expected 0", sb[0].req, sb.size());
        end
        summary();
        $finish;
    end

endmodule